// File: doc/BRIEF.md
# Strobed External Memory Bus Master

This block turns single read or write requests from an on-chip master into bus cycles on an external asynchronous memory. The external bus has a 16-bit address, an 8-bit data path split into input, output and output-enable, an enable strobe and a read/write line. Each external bus cycle takes two system clocks. In the first clock the strobe is high and the address and direction are presented. In the second clock the strobe is low, and for a write the data bus is driven. The edge that ends the second clock is the strobe's next rising edge. At that edge read data is captured and write data is released.

The 64 KB address space is split in two. A contiguous window, 6 KB by default at the top of the space, belongs to on-chip resources. A request that falls in the window goes to a simple internal port and completes in a single clock, with no activity on the external bus. Every other address, including the low 16 KB that usually holds system firmware, gets an external cycle. While one external cycle is in its strobe-low clock, the next external request can be accepted, so back-to-back cycles keep the strobe running with no gap.

Top module: `ext_mem_master`

## Requirements
- R1: After reset, the outputs are as follows: `bus_e_o` is 0, `bus_rw_o` is 1, `bus_d_oe_o` is 0, `bus_addr_o` is 0, `done_o` is 0, `rdata_o` is 0 and `ready_o` is 1.
- R2: A request to an external address that is accepted at a clock edge drives `bus_e_o` high for exactly the next clock and low for the clock after. `bus_addr_o` and `bus_rw_o` take the request's values at the accepting edge. They keep those values until the next external request is accepted, so they are held across the edge that ends the cycle.
- R3: `bus_rw_o` is 1 for a read (`we_i`=0) and 0 for a write (`we_i`=1).
- R4: During an external read, `bus_d_oe_o` stays 0 for the whole cycle. At the edge that ends the strobe-low clock, `rdata_o` takes the value on `bus_d_i`.
- R5: During an external write, `bus_d_oe_o` is 1 only during the strobe-low clock, and during that clock `bus_d_o` carries the request's `wdata_i`. The bus is released at the edge that ends the cycle.
- R6: An address in the range INT_BASE to INT_BASE+INT_SIZE-1 (default 0xE800 to 0xFFFF) is served on-chip. For such a request, `int_sel_o` is 1 in the accepting cycle, with `int_addr_o`, `int_we_o` and `int_wdata_o` taken from the request. `bus_e_o` stays 0 and `bus_addr_o` does not change. For a read, `rdata_o` takes `int_rdata_i` as sampled at the accepting edge.
- R7: `ready_o` is 1 when no cycle is in progress. During the strobe-low clock of an external cycle, `ready_o` is 1 only if the presented address is external. An external request accepted in that clock starts its strobe-high clock right away, with no idle clock in between.
- R8: A write, whether external or on-chip, never changes `rdata_o`.
- R9: The window decode is exact at its boundaries. 0xE7FF and 0x0000 are external; 0xE800 and 0xFFFF are on-chip.
- R10: `done_o` pulses high for exactly one clock per accepted request. For an on-chip request the pulse comes in the clock after acceptance. For an external request it comes in the clock after the strobe-low clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Request address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Request can be accepted this clock |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Last read data |
| int_sel_o | output | 1 | On-chip access strobe |
| int_we_o | output | 1 | On-chip write enable |
| int_addr_o | output | 16 | On-chip access address |
| int_wdata_o | output | 8 | On-chip write data |
| int_rdata_i | input | 8 | On-chip read data |
| bus_addr_o | output | 16 | External address bus |
| bus_rw_o | output | 1 | External read/write line, 1 = read |
| bus_e_o | output | 1 | External enable strobe |
| bus_d_o | output | 8 | External data out |
| bus_d_oe_o | output | 1 | External data output enable |
| bus_d_i | input | 8 | External data in |

## Verification
When external cycles run back to back, two events fall on the same clock edge. The edge that ends one cycle captures read data for that cycle, and it also launches the address and direction of the next cycle. The bench provokes this by holding a write request to a new address through the strobe-low clock of a read. It then checks that `rdata_o` matches the memory model's value for the old address, while `bus_addr_o`, `bus_rw_o` and the strobe already show the new write. A second contention comes from offering an on-chip address in that same strobe-low clock. The bench checks that this request is refused until the bus is idle.

// File: rtl/em_pkg.sv
package em_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2
  } em_phase_e;
endpackage

// File: rtl/em_window_dec.sv
module em_window_dec #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned INT_BASE = 32'hE800,
  parameter int unsigned INT_SIZE = 32'h1800
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              on_chip_o
);
  localparam logic [ADDR_W:0] LO_B = (ADDR_W+1)'(INT_BASE);
  localparam logic [ADDR_W:0] HI_B = (ADDR_W+1)'(INT_BASE + INT_SIZE - 1);

  generate
    if (INT_SIZE == 0) begin : g_none
      assign on_chip_o = 1'b0;
    end else begin : g_win
      logic [ADDR_W:0] a_ext;
      assign a_ext     = {1'b0, addr_i};
      assign on_chip_o = (a_ext >= LO_B) && (a_ext <= HI_B);
    end
  endgenerate
endmodule

// File: rtl/em_seq.sv
module em_seq
  import em_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ext_go_i,
  output em_phase_e phase_o,
  output logic      e_o
);
  em_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (ext_go_i) phase_d = PH_HI;
      PH_HI:   phase_d = PH_LO;
      PH_LO:   phase_d = ext_go_i ? PH_HI : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign e_o     = (phase_q == PH_HI);

  // strobe high lasts one clock
  assert_e_one_clk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_o |=> !e_o);
  // no new strobe while HI
  assert_hi_no_go_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_o |-> !ext_go_i);
endmodule

// File: rtl/em_dpath.sv
module em_dpath
  import em_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  em_phase_e         phase_i,
  input  logic              ext_go_i,
  input  logic              int_go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] int_rdata_i,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rw_o,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q;
  logic [DATA_W-1:0] wd_q;
  logic              oe_q;
  logic [DATA_W-1:0] rd_q;
  logic              done_q;
  logic              cyc_end;

  assign cyc_end = (phase_i == PH_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rw_q   <= 1'b1;
      wd_q   <= '0;
    end else if (ext_go_i) begin
      addr_q <= addr_i;
      rw_q   <= ~we_i;
      wd_q   <= wdata_i;
    end
  end

  // drive in E-low clock only, release at the next rising E
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= (phase_i == PH_HI) && !rw_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= cyc_end || int_go_i;
      if (cyc_end && rw_q)        rd_q <= bus_d_i;
      else if (int_go_i && !we_i) rd_q <= int_rdata_i;
    end
  end

  assign bus_addr_o = addr_q;
  assign bus_rw_o   = rw_q;
  assign bus_d_o    = wd_q;
  assign bus_d_oe_o = oe_q;
  assign rdata_o    = rd_q;
  assign done_o     = done_q;

  assert_read_no_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rw_o |-> !bus_d_oe_o);
  assert_oe_one_clk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_d_oe_o |=> !bus_d_oe_o);
  assert_oe_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_d_oe_o |-> $stable(bus_d_o));
endmodule

// File: rtl/ext_mem_master.sv
module ext_mem_master
  import em_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned INT_BASE = 32'hE800,
  parameter int unsigned INT_SIZE = 32'h1800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              int_sel_o,
  output logic              int_we_o,
  output logic [ADDR_W-1:0] int_addr_o,
  output logic [DATA_W-1:0] int_wdata_o,
  input  logic [DATA_W-1:0] int_rdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rw_o,
  output logic              bus_e_o,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe_o,
  input  logic [DATA_W-1:0] bus_d_i
);
  em_phase_e phase;
  logic      on_chip, accept, ext_go, int_go;

  em_window_dec #(
    .ADDR_W  (ADDR_W),
    .INT_BASE(INT_BASE),
    .INT_SIZE(INT_SIZE)
  ) u_dec (
    .addr_i   (addr_i),
    .on_chip_o(on_chip)
  );

  // on-chip access only from idle; external may chain from E-low
  assign ready_o = (phase == PH_IDLE) || ((phase == PH_LO) && !on_chip);
  assign accept  = req_i && ready_o;
  assign ext_go  = accept && !on_chip;
  assign int_go  = accept && on_chip;

  em_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ext_go_i(ext_go),
    .phase_o (phase),
    .e_o     (bus_e_o)
  );

  em_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .ext_go_i   (ext_go),
    .int_go_i   (int_go),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .int_rdata_i(int_rdata_i),
    .bus_d_i    (bus_d_i),
    .bus_addr_o (bus_addr_o),
    .bus_rw_o   (bus_rw_o),
    .bus_d_o    (bus_d_o),
    .bus_d_oe_o (bus_d_oe_o),
    .rdata_o    (rdata_o),
    .done_o     (done_o)
  );

  assign int_sel_o   = int_go;
  assign int_we_o    = we_i;
  assign int_addr_o  = addr_i;
  assign int_wdata_o = wdata_i;

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_e_o |=> ($stable(bus_addr_o) && $stable(bus_rw_o)));
  assert_int_no_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sel_o |=> (!bus_e_o && $stable(bus_addr_o)));
  assert_int_idle_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sel_o |-> (!bus_e_o && !bus_d_oe_o));
  assert_done_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(int_sel_o) || $past(bus_d_oe_o) || $past(phase == PH_LO)));
  assert_write_keeps_rdata_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_sel_o && int_we_o) |=> $stable(rdata_o));
endmodule

// File: tb/ext_mem_master_tb_top.sv
module ext_mem_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  int_rdata = '0;
  logic        ready, done, int_sel, int_we, bus_rw, bus_e, bus_oe;
  logic [7:0]  rdata, int_wdata, bus_do, bus_di;
  logic [15:0] int_addr, bus_addr;
  int          checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign bus_di = mem_val(bus_addr);

  ext_mem_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .int_sel_o(int_sel), .int_we_o(int_we), .int_addr_o(int_addr),
    .int_wdata_o(int_wdata), .int_rdata_i(int_rdata), .bus_addr_o(bus_addr),
    .bus_rw_o(bus_rw), .bus_e_o(bus_e), .bus_d_o(bus_do), .bus_d_oe_o(bus_oe),
    .bus_d_i(bus_di)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // present request at negedge, accepted at posedge, return at next negedge
  task automatic issue(input logic [15:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; addr = a; we = w; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset();
    chk(bus_e == 1'b0, "R1 e", bus_e, 0);
    chk(bus_rw == 1'b1, "R1 rw", bus_rw, 1);
    chk(bus_oe == 1'b0, "R1 oe", bus_oe, 0);
    chk(bus_addr == 16'h0, "R1 addr", bus_addr, 0);
    chk(done == 1'b0 && rdata == 8'h0, "R1 done/rdata", {done, rdata}, 0);
    chk(ready == 1'b1, "R1 ready", ready, 1);
  endtask

  task automatic t_ext_read(input logic [15:0] a, input string rq);
    issue(a, 1'b0, 8'h00);
    chk(bus_e == 1'b1 && bus_addr == a, {rq, " R2 hi/addr"}, {bus_e, bus_addr}, {1'b1, a});
    chk(bus_rw == 1'b1 && bus_oe == 1'b0, "R3 rw read", {bus_rw, bus_oe}, 2'b10);
    chk(ready == 1'b0, "R7 busy hi", ready, 0);
    @(negedge clk);
    chk(bus_e == 1'b0 && bus_oe == 1'b0, "R4 lo no drive", {bus_e, bus_oe}, 0);
    chk(done == 1'b0, "R10 not yet", done, 0);
    @(negedge clk);
    chk(done == 1'b1 && rdata == mem_val(a), {rq, " R4 capture"}, rdata, mem_val(a));
    chk(bus_e == 1'b0 && bus_addr == a, "R2 hold after", bus_addr, a);
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", done, 0);
  endtask

  task automatic t_ext_write(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] prev;
    prev = rdata;
    issue(a, 1'b1, d);
    chk(bus_e == 1'b1 && bus_rw == 1'b0, "R3 rw write", {bus_e, bus_rw}, 2'b10);
    chk(bus_oe == 1'b0, "R5 no drive in hi", bus_oe, 0);
    @(negedge clk);
    chk(bus_oe == 1'b1 && bus_do == d, "R5 drive in lo", {bus_oe, bus_do}, {1'b1, d});
    @(negedge clk);
    chk(bus_oe == 1'b0 && done == 1'b1, "R5 release/done", {bus_oe, done}, 2'b01);
    chk(rdata == prev, "R8 ext write", rdata, prev);
  endtask

  task automatic t_internal(input logic [15:0] a, input logic w, input logic [7:0] d,
                            input string rq);
    logic [15:0] held;
    logic [7:0]  prev;
    held = bus_addr; prev = rdata;
    int_rdata = d ^ 8'hA5;
    @(negedge clk);
    req = 1'b1; addr = a; we = w; wdata = d;
    #1;
    chk(int_sel == 1'b1 && int_addr == a, {rq, " R6 sel"}, {int_sel, int_addr}, {1'b1, a});
    chk(int_we == w && int_wdata == d, "R6 fields", {int_we, int_wdata}, {w, d});
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk(bus_e == 1'b0 && bus_addr == held, {rq, " R6 no bus"}, bus_addr, held);
    chk(done == 1'b1, "R10 int done", done, 1);
    if (w) chk(rdata == prev, "R8 int write", rdata, prev);
    else   chk(rdata == (d ^ 8'hA5), "R6 int read", rdata, d ^ 8'hA5);
    @(negedge clk);
    chk(done == 1'b0, "R10 int single", done, 0);
  endtask

  // capture of read A and launch of write B share one edge
  task automatic t_back2back();
    logic [15:0] a, b;
    a = 16'h1234; b = 16'h4321;
    issue(a, 1'b0, 8'h00);
    req = 1'b1; addr = 16'hF000; we = 1'b0;
    @(negedge clk);
    #1;
    chk(ready == 1'b0 && int_sel == 1'b0, "R7 on-chip refused in lo", {ready, int_sel}, 0);
    addr = b; we = 1'b1; wdata = 8'h9E;
    #1;
    chk(ready == 1'b1, "R7 ext ready in lo", ready, 1);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk(done == 1'b1 && rdata == mem_val(a), "R4 R7 capture old", rdata, mem_val(a));
    chk(bus_e == 1'b1 && bus_addr == b && bus_rw == 1'b0, "R7 launch new",
        {bus_e, bus_rw, bus_addr}, {2'b10, b});
    @(negedge clk);
    chk(bus_oe == 1'b1 && bus_do == 8'h9E && done == 1'b0, "R5 R10 b2b write",
        {bus_oe, done, bus_do}, {2'b10, 8'h9E});
    @(negedge clk);
    chk(done == 1'b1 && bus_oe == 1'b0, "R10 b2b done", {done, bus_oe}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_read(16'h0000, "R9 low");
    t_ext_read(16'hE7FF, "R9 below");
    t_ext_write(16'h2A5C, 8'h6D);
    t_internal(16'hE800, 1'b0, 8'h11, "R9 base");
    t_internal(16'hFFFF, 1'b1, 8'h22, "R9 top");
    t_internal(16'hF123, 1'b0, 8'h47, "R6 mid");
    t_back2back();
    t_ext_read(16'h3FFF, "R2 firmware top");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule